// File: doc/BRIEF.md
# Cascadable Priority Interrupt Controller

This block gathers eight interrupt lines into one interrupt output for a processor. Software reaches it over a byte-wide write bus with two addresses, one for commands and one for data. A command carrying the initialization flag starts a short set-up sequence. The data writes that follow supply, in turn, a vector base, a cascade word and, when asked for, a mode word. Once that sequence ends, data writes load an 8-bit mask.

A rising edge on an input line latches a request, and the request stays pending until it is acknowledged. Line 0 has the highest priority and line 7 the lowest, and that order is fixed. The interrupt output is raised for the best unmasked pending line, but only when no line of the same or higher priority is in service. An acknowledge moves the winning line into service and answers one cycle later. The answer is either a vector byte equal to base plus line number, or, on a master whose winning line has a slave attached, the line number on the cascade output.

A non-specific end-of-interrupt command takes the highest-priority line out of service. One instance strapped as master and one as slave can be chained: wire the master's cascade output to the slave's acknowledge and select inputs.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, int_out, vec_valid and cas_valid are 0, and an acknowledge with nothing pending gives no vector and no cascade answer.
- R2: A command-address write with bit 4 set restarts set-up. The next data write is the vector base and the one after it is the cascade word. If bit 0 of the restarting command was 1, one more data write is consumed as the mode word. Every data write after that loads the mask.
- R3: Data writes made before set-up is complete never change the mask.
- R4: The mask comes out of reset, and out of every restart, as all ones. A 1 in mask bit n blocks line n, and a 0 lets it through. A request on a blocked line stays pending and is raised as soon as its bit is cleared.
- R5: A request is latched on a rising edge of its line and kept until acknowledged, even if the line falls first. A line held high does not request again after it has been acknowledged.
- R6: Line 0 has the highest priority. int_out is 1 only if the best unmasked pending line has strictly higher priority than every line in service.
- R7: When acknowledge is sampled while int_out is 1, the winning line moves from pending to in service. On the following cycle only, vec_valid is 1 and vec_out is (base + line) mod 256. An acknowledge taken while int_out is 0 has no effect.
- R8: A command write of 0x20 takes the highest-priority line out of service. A command write with bit 4 clear and any other value has no effect.
- R9: On a master whose cascade word has bit n set, acknowledging line n gives cas_valid = 1 with cas_out = n one cycle later, and vec_valid stays 0.
- R10: On a slave, bits 2..0 of the cascade word are its own identity. The slave takes an acknowledge only when cas_in equals that identity. It never drives cas_valid.
- R11: A line in service, including a master's cascade line, is not raised again until an end-of-interrupt removes it from service.
- R12: A restart also clears every pending request and every in-service line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| is_master | input | 1 | 1 = master role, 0 = slave role |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | 1 | 0 = command address, 1 = data address |
| bus_wdata | input | 8 | Write data |
| irq_in | input | 8 | Interrupt request lines |
| ack | input | 1 | Acknowledge pulse |
| cas_in | input | 3 | Line number chosen by the master (used by a slave) |
| int_out | output | 1 | Interrupt output |
| vec_valid | output | 1 | One-cycle strobe for vec_out |
| vec_out | output | 8 | Vector byte |
| cas_valid | output | 1 | One-cycle strobe for cas_out |
| cas_out | output | 3 | Cascade line number sent to slaves |

## Verification
The resolver is tried with single requests, with two lines raised in the same cycle, and with nested arrivals, where a better line comes in while a worse one is in service and then a worse one comes in behind it. These patterns show fixed priority apart from arrival order, and show that the in-service blocking works. The set-up sequence is run both with and without the mode word. A zero written where the mode word belongs then shows whether it was consumed or taken as a mask. Master answers on a cascade line, slave answers with a matching and with a wrong select, a base that wraps past 255, and a restart in the middle of activity show that the vector and cascade paths stay apart and that restart clears all state.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int DATA_W = 8;
  localparam int INIT_FLAG_BIT = 4;
  localparam int WANT_MODE_BIT = 0;
  localparam logic [DATA_W-1:0] EOI_CMD = 8'h20;

  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_BASE,
    SEQ_CASC,
    SEQ_MODE,
    SEQ_RUN
  } seq_state_e;

  function automatic logic [DATA_W-1:0] vector_for(input logic [DATA_W-1:0] base,
                                                   input logic [DATA_W-1:0] line);
    return base + line;
  endfunction
endpackage

// File: rtl/irq_init_seq.sv
module irq_init_seq
  import irq_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_wr,
  input  logic              data_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic              restart,
  output logic              mask_wr,
  output logic              running,
  output logic [DATA_W-1:0] base_q,
  output logic [DATA_W-1:0] casc_q
);
  seq_state_e st_q;
  logic       want_mode_q;

  assign restart = cmd_wr && wdata[INIT_FLAG_BIT];
  assign running = (st_q == SEQ_RUN);
  assign mask_wr = data_wr && running;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= SEQ_IDLE;
      want_mode_q <= 1'b0;
      base_q      <= '0;
      casc_q      <= '0;
    end else if (restart) begin
      st_q        <= SEQ_BASE;
      want_mode_q <= wdata[WANT_MODE_BIT];
    end else if (data_wr) begin
      case (st_q)
        SEQ_BASE: begin
          base_q <= wdata;
          st_q   <= SEQ_CASC;
        end
        SEQ_CASC: begin
          casc_q <= wdata;
          st_q   <= want_mode_q ? SEQ_MODE : SEQ_RUN;
        end
        SEQ_MODE: st_q <= SEQ_RUN;
        default:  st_q <= st_q;
      endcase
    end
  end

  AST_RESTART_TO_BASE: assert property (@(posedge clk) disable iff (rst)
    $past(restart) |-> st_q == SEQ_BASE); // R2
endmodule

// File: rtl/irq_prio_resolve.sv
module irq_prio_resolve #(
  parameter int NLINES = 8,
  parameter int IDXW   = 3
) (
  input  logic [NLINES-1:0] req,
  input  logic [NLINES-1:0] mask,
  input  logic [NLINES-1:0] isr,
  output logic              fire,
  output logic [IDXW-1:0]   win_idx,
  output logic              srv_any,
  output logic [IDXW-1:0]   srv_idx
);
  function automatic logic [IDXW-1:0] best_line(input logic [NLINES-1:0] v);
    logic [IDXW-1:0] r;
    r = '0;
    for (int i = NLINES - 1; i >= 0; i--) begin
      if (v[i]) r = IDXW'(i);
    end
    return r;
  endfunction

  logic [NLINES-1:0] elig;
  logic              elig_any;

  assign elig     = req & ~mask;
  assign elig_any = |elig;
  assign win_idx  = best_line(elig);
  assign srv_any  = |isr;
  assign srv_idx  = best_line(isr);
  assign fire     = elig_any && (!srv_any || (win_idx < srv_idx));
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int NLINES = 8,
  localparam int IDXW  = $clog2(NLINES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              is_master,
  input  logic              bus_wr,
  input  logic              bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [NLINES-1:0] irq_in,
  input  logic              ack,
  input  logic [IDXW-1:0]   cas_in,
  output logic              int_out,
  output logic              vec_valid,
  output logic [DATA_W-1:0] vec_out,
  output logic              cas_valid,
  output logic [IDXW-1:0]   cas_out
);
  localparam logic [NLINES-1:0] ONE_HOT0 = NLINES'(1);

  logic              cmd_wr, data_wr, restart, mask_wr, running;
  logic [DATA_W-1:0] base_q, casc_q;
  logic [NLINES-1:0] irq_d, req_q, isr_q, mask_q;
  logic              fire, srv_any;
  logic [IDXW-1:0]   win_idx, srv_idx;

  // Named events used by the datapath and the assertions
  logic              eoi_evt, selected, take, to_slave;
  logic [NLINES-1:0] rise, win_oh, eoi_oh;

  assign cmd_wr  = bus_wr && !bus_addr;
  assign data_wr = bus_wr && bus_addr;

  irq_init_seq u_seq (
    .clk     (clk),
    .rst     (rst),
    .cmd_wr  (cmd_wr),
    .data_wr (data_wr),
    .wdata   (bus_wdata),
    .restart (restart),
    .mask_wr (mask_wr),
    .running (running),
    .base_q  (base_q),
    .casc_q  (casc_q)
  );

  irq_prio_resolve #(.NLINES(NLINES), .IDXW(IDXW)) u_res (
    .req     (req_q),
    .mask    (mask_q),
    .isr     (isr_q),
    .fire    (fire),
    .win_idx (win_idx),
    .srv_any (srv_any),
    .srv_idx (srv_idx)
  );

  assign int_out  = fire;
  assign rise     = irq_in & ~irq_d;
  assign eoi_evt  = cmd_wr && (bus_wdata == EOI_CMD);
  assign selected = is_master || (cas_in == casc_q[IDXW-1:0]);
  assign take     = ack && fire && selected;
  assign to_slave = is_master && casc_q[win_idx];
  assign win_oh   = take ? (ONE_HOT0 << win_idx) : '0;
  assign eoi_oh   = (eoi_evt && srv_any) ? (ONE_HOT0 << srv_idx) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_d     <= '0;
      req_q     <= '0;
      isr_q     <= '0;
      mask_q    <= '1;
      vec_valid <= 1'b0;
      vec_out   <= '0;
      cas_valid <= 1'b0;
      cas_out   <= '0;
    end else begin
      irq_d     <= irq_in;
      vec_valid <= 1'b0;
      cas_valid <= 1'b0;
      if (restart) begin
        req_q  <= '0;
        isr_q  <= '0;
        mask_q <= '1;
      end else begin
        if (mask_wr) mask_q <= bus_wdata[NLINES-1:0];
        req_q <= (req_q & ~win_oh) | rise;
        isr_q <= (isr_q | win_oh) & ~eoi_oh;
        if (take) begin
          if (to_slave) begin
            cas_valid <= 1'b1;
            cas_out   <= win_idx;
          end else begin
            vec_valid <= 1'b1;
            vec_out   <= vector_for(base_q, DATA_W'(win_idx));
          end
        end
      end
    end
  end

  AST_INT_HAS_SOURCE: assert property (@(posedge clk) disable iff (rst)
    int_out |-> |(req_q & ~mask_q)); // R6
  AST_TOP_SERVICE_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    isr_q[0] |-> !int_out); // R6
  AST_MASK_LOCKED: assert property (@(posedge clk) disable iff (rst)
    !$past(running) |-> mask_q == '1); // R3
  AST_VEC_FROM_ACK: assert property (@(posedge clk) disable iff (rst)
    vec_valid |-> $past(ack)); // R7
  AST_ONE_ANSWER: assert property (@(posedge clk) disable iff (rst)
    !(vec_valid && cas_valid)); // R9
  AST_SLAVE_NO_CAS: assert property (@(posedge clk) disable iff (rst)
    cas_valid |-> $past(is_master)); // R10
  AST_EOI_DROPS: assert property (@(posedge clk) disable iff (rst)
    (eoi_evt && srv_any) |=> !isr_q[$past(srv_idx)]); // R8
endmodule

// File: tb/tb_irq_prio_ctrl.sv
module tb_irq_prio_ctrl;
  logic       clk = 1'b0;
  logic       rst;
  logic       is_master;
  logic       bus_wr, bus_addr;
  logic [7:0] bus_wdata;
  logic [7:0] irq_in;
  logic       ack;
  logic [2:0] cas_in;
  logic       int_out, vec_valid, cas_valid;
  logic [7:0] vec_out;
  logic [2:0] cas_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_prio_ctrl dut (
    .clk(clk), .rst(rst), .is_master(is_master), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .irq_in(irq_in), .ack(ack),
    .cas_in(cas_in), .int_out(int_out), .vec_valid(vec_valid),
    .vec_out(vec_out), .cas_valid(cas_valid), .cas_out(cas_out)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic addr, input logic [7:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = addr; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic setup(input logic master, input logic [7:0] base,
                       input logic [7:0] casc, input logic with_mode);
    is_master = master;
    wr(1'b0, 8'h10 | {7'd0, with_mode});
    wr(1'b1, base);
    wr(1'b1, casc);
    if (with_mode) wr(1'b1, 8'h01);
  endtask

  task automatic raise(input logic [7:0] bits);
    @(negedge clk); irq_in = irq_in | bits;
    @(negedge clk);
  endtask

  task automatic drop_all();
    @(negedge clk); irq_in = '0;
    @(negedge clk);
  endtask

  task automatic do_ack(input logic [2:0] sel);
    @(negedge clk); ack = 1'b1; cas_in = sel;
    @(negedge clk); ack = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "int_out after reset", int_out, 0);
    chk("R1", "vec_valid after reset", vec_valid, 0);
    chk("R1", "cas_valid after reset", cas_valid, 0);
    do_ack(3'd0);
    chk("R1", "vec_valid on idle ack", vec_valid, 0);
    chk("R1", "cas_valid on idle ack", cas_valid, 0);
  endtask

  task automatic t_preinit_mask();
    wr(1'b1, 8'h00);               // R3: data write while idle
    setup(1'b1, 8'h20, 8'h00, 1'b1);
    raise(8'h20);
    chk("R3", "int_out, mask untouched before set-up", int_out, 0);
    chk("R4", "int_out, mask all ones", int_out, 0);
    wr(1'b1, 8'hDF);
    chk("R4", "pending line fires once unmasked", int_out, 1);
    do_ack(3'd0);
    chk("R7", "vec_valid", vec_valid, 1);
    chk("R7", "vec_out base+5", vec_out, 8'h25);
    @(negedge clk);
    chk("R7", "vec_valid lasts one cycle", vec_valid, 0);
    wr(1'b0, 8'h20);
    drop_all();
  endtask

  task automatic t_sequence();
    setup(1'b1, 8'h30, 8'h00, 1'b1);
    wr(1'b1, 8'h00);
    raise(8'h02);
    chk("R2", "line fires after mask write", int_out, 1);
    do_ack(3'd0);
    chk("R2", "vec_out with mode word", vec_out, 8'h31);
    wr(1'b0, 8'h20);
    drop_all();
    setup(1'b1, 8'h50, 8'h00, 1'b1);
    raise(8'h02);
    chk("R2", "mode word not taken as mask", int_out, 0);
    setup(1'b1, 8'h60, 8'h00, 1'b0);
    wr(1'b1, 8'h00);
    drop_all();
    raise(8'h02);
    chk("R2", "third write is mask without mode word", int_out, 1);
    do_ack(3'd0);
    chk("R2", "vec_out without mode word", vec_out, 8'h61);
    wr(1'b0, 8'h20);
    drop_all();
  endtask

  task automatic t_priority();
    setup(1'b1, 8'h08, 8'h00, 1'b1);
    wr(1'b1, 8'h00);
    raise(8'h48);
    chk("R6", "int_out with lines 3 and 6", int_out, 1);
    do_ack(3'd0);
    chk("R6", "line 3 wins", vec_out, 8'h0B);
    chk("R6", "line 6 blocked by line 3 in service", int_out, 0);
    wr(1'b0, 8'h20);
    chk("R8", "line 6 raised after EOI", int_out, 1);
    do_ack(3'd0);
    chk("R6", "line 6 served", vec_out, 8'h0E);
    wr(1'b0, 8'h20);
    drop_all();
  endtask

  task automatic t_nesting();
    setup(1'b1, 8'h10, 8'h00, 1'b1);
    wr(1'b1, 8'h00);
    raise(8'h20);
    do_ack(3'd0);
    chk("R7", "line 5 vector", vec_out, 8'h15);
    raise(8'h04);
    chk("R6", "line 2 preempts line 5", int_out, 1);
    do_ack(3'd0);
    chk("R6", "line 2 vector", vec_out, 8'h12);
    raise(8'h10);
    chk("R6", "line 4 waits behind line 2", int_out, 0);
    wr(1'b0, 8'h0A);
    chk("R8", "other command has no effect", int_out, 0);
    wr(1'b0, 8'h20);
    chk("R8", "EOI removes line 2 first", int_out, 1);
    do_ack(3'd0);
    chk("R8", "line 4 vector", vec_out, 8'h14);
    wr(1'b0, 8'h20);
    wr(1'b0, 8'h20);
    chk("R8", "all served", int_out, 0);
    drop_all();
  endtask

  task automatic t_edges();
    setup(1'b1, 8'hFC, 8'h00, 1'b1);
    wr(1'b1, 8'h00);
    raise(8'h02);
    do_ack(3'd0);
    wr(1'b0, 8'h20);
    @(negedge clk);
    chk("R5", "held line does not request again", int_out, 0);
    raise(8'h80);
    @(negedge clk); irq_in[7] = 1'b0;
    @(negedge clk);
    chk("R5", "request kept after line falls", int_out, 1);
    do_ack(3'd0);
    chk("R7", "vector wraps past 255", vec_out, 8'h03);
    wr(1'b0, 8'h20);
    drop_all();
  endtask

  task automatic t_master_cascade();
    setup(1'b1, 8'h40, 8'h04, 1'b1);
    wr(1'b1, 8'h00);
    raise(8'h04);
    do_ack(3'd0);
    chk("R9", "cas_valid", cas_valid, 1);
    chk("R9", "cas_out", cas_out, 2);
    chk("R9", "no vector on cascade line", vec_valid, 0);
    drop_all();
    raise(8'h04);
    chk("R11", "cascade line blocked while in service", int_out, 0);
    wr(1'b0, 8'h20);
    chk("R11", "cascade line raised after EOI", int_out, 1);
    do_ack(3'd0);
    chk("R9", "second cascade answer", cas_valid, 1);
    wr(1'b0, 8'h20);
    drop_all();
  endtask

  task automatic t_slave();
    setup(1'b0, 8'h70, 8'h02, 1'b1);
    wr(1'b1, 8'h00);
    raise(8'h01);
    do_ack(3'd3);
    chk("R10", "wrong select ignored", vec_valid, 0);
    chk("R10", "request still raised", int_out, 1);
    do_ack(3'd2);
    chk("R10", "matching select answered", vec_out, 8'h70);
    chk("R10", "slave never drives cascade", cas_valid, 0);
    wr(1'b0, 8'h20);
    drop_all();
    is_master = 1'b1;
  endtask

  task automatic t_restart();
    setup(1'b1, 8'h40, 8'h00, 1'b1);
    wr(1'b1, 8'h00);
    raise(8'h08);
    do_ack(3'd0);
    raise(8'h20);
    wr(1'b0, 8'h11);
    chk("R12", "int_out after restart", int_out, 0);
    wr(1'b1, 8'h40); wr(1'b1, 8'h00); wr(1'b1, 8'h01);
    wr(1'b1, 8'h00);
    chk("R12", "pending request cleared", int_out, 0);
    drop_all();
    raise(8'h20);
    chk("R12", "in-service cleared", int_out, 1);
    do_ack(3'd0);
    chk("R12", "line 5 vector", vec_out, 8'h45);
    wr(1'b0, 8'h20);
    drop_all();
  endtask

  initial begin
    #400000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; is_master = 1'b1; bus_wr = 1'b0; bus_addr = 1'b0;
    bus_wdata = '0; irq_in = '0; ack = 1'b0; cas_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    t_reset();
    t_preinit_mask();
    t_sequence();
    t_priority();
    t_nesting();
    t_edges();
    t_master_cascade();
    t_slave();
    t_restart();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule